// File: doc/BRIEF.md
# Goldschmidt Significand Divider

This block divides one normalized fixed-point significand by another. It does this by converging through multiplication, not by subtracting digit by digit. Both operands are unsigned values in [1, 2) with one integer bit and M-1 fraction bits. The block returns a quotient approximation in the same format, in the range (0.5, 2).

A small reciprocal table gives a starting estimate of 1/B. It is indexed by the fraction bits of the divisor that sit just below its leading one. The numerator and the denominator are first scaled by this estimate. Then, for a fixed number of rounds, both are multiplied by a correction factor. The factor is formed as the one's complement of the current denominator, which approximates 2 - d. Every product is truncated to M bits. A small constant increment is added to the last numerator product to give the result.

One multiplier is shared. A step sequencer feeds it the numerator product and the denominator product on alternate cycles. The block is meant to sit under an exponent and rounding stage that deals with packing, special values and the final rounding.

Top module: `gs_divider`

## Requirements
- R1: While reset is held and in the first cycle after reset, `done` is 0 and `q` is 0.
- R2: For any `a_in` and `b_in` in [1, 2) (bit M-1 set), `q` lies within 12 units of 2^-(M-1) of floor(a_in * 2^(M-1) / b_in). The default parameters give 3 correction rounds, a 64-entry seed table indexed by the 6 bits below the divisor's leading one, and 8-bit seeds rounded to nearest.
- R3: A start sampled at a clock edge while the block is idle is answered by `done` exactly 2*ITERS+1 clock edges later, which is 7 with the defaults.
- R4: `done` stays high for exactly one cycle per accepted start.
- R5: `q` changes only in a cycle in which `done` is high and otherwise keeps its last value, whatever `start`, `a_in` and `b_in` do.
- R6: A start that arrives while a division is running is ignored. It produces no extra `done`, and the running result still belongs to the operands that were first accepted.
- R7: Equal operands give a quotient within tolerance of 1.0. The divisor 1.0 returns the dividend within tolerance.
- R8: The result never wraps. A dividend close to 2 divided by 1.0 gives a value within tolerance of the all-ones code, and intermediate products at or above 2 saturate to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division; sampled only while idle |
| a_in | input | M | Dividend, unsigned Q1.(M-1) in [1, 2) |
| b_in | input | M | Divisor, unsigned Q1.(M-1) in [1, 2) |
| done | output | 1 | One-cycle pulse when `q` is updated |
| q | output | M | Quotient approximation, Q1.(M-1) |

## Verification
The in-line properties check the control sequence on every cycle. Each running step advances by one. The last step is followed by a single `done` pulse and a return to idle. A start while running does not restart the sequence, the latched operands stay frozen during a run, and the denominator stays normalized near 1 once it has been scaled. Whether the arithmetic is correct can only be seen from the bench. It compares each quotient against the exact truncated quotient over directed boundary operands and a pseudo-random sweep. It also measures latency from the accepting edge, and it shows that a start while running leaves the result unchanged.

// File: rtl/gs_pkg.sv
// Package: shared types and constant functions for the Goldschmidt divider.
// Assumes callers pass small widths (index width + seed width well below 60).
package gs_pkg;

    // Sequencer state.
    typedef enum logic {
        GS_IDLE = 1'b0,
        GS_RUN  = 1'b1
    } gs_state_e;

    // Reciprocal seed for table slot i: 1/(midpoint of the slot), scaled by
    // 2^sw and rounded to nearest. The slot covers [1 + i/2^iw, 1 + (i+1)/2^iw).
    function automatic longint unsigned seed_value(longint unsigned i,
                                                   longint unsigned iw,
                                                   longint unsigned sw);
        longint unsigned num;
        longint unsigned den;
        num = 64'd1 << (sw + iw + 64'd1);
        den = (64'd1 << (iw + 64'd1)) + 64'd2 * i + 64'd1;
        return (64'd2 * num + den) / (64'd2 * den);
    endfunction

endpackage

// File: rtl/gs_seed_rom.sv
// Reciprocal seed table. The entries are computed at elaboration, one per index
// value. The output is the seed placed in Q1.(M-1) format (integer bit zero).
// Assumes M-1 > SW so that the seed fits below the integer bit.
module gs_seed_rom #(
    parameter int M    = 24,
    parameter int IDXW = 6,
    parameter int SW   = 8
) (
    input  logic [IDXW-1:0] idx,
    output logic [M-1:0]    t
);
    localparam int DEPTH = 1 << IDXW;
    localparam int PADW  = M - 1 - SW;

    logic [SW-1:0] seeds [DEPTH];

    // One constant entry per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_seed
        assign seeds[g] = SW'(gs_pkg::seed_value(64'(g), 64'(IDXW), 64'(SW)));
    end

    // Place the seed as a pure fraction in Q1.(M-1).
    assign t = {1'b0, seeds[idx], {PADW{1'b0}}};

endmodule

// File: rtl/gs_mul_trunc.sv
// Shared multiplier: the product of two Q1.(M-1) values is truncated back to
// Q1.(M-1). A product of 2 or more saturates to all ones so that it never wraps.
module gs_mul_trunc #(
    parameter int M = 24
) (
    input  logic [M-1:0] x,
    input  logic [M-1:0] y,
    output logic [M-1:0] p
);
    localparam int PW = 2 * M;

    logic [PW-1:0] full;

    // Full-width product in Q2.(2M-2).
    assign full = PW'(x) * PW'(y);

    // Drop the low M-1 fraction bits, or clamp when the integer part reaches 2.
    assign p = full[PW-1] ? {M{1'b1}} : M'(full >> (M - 1));

endmodule

// File: rtl/gs_ctrl.sv
// Step sequencer. It accepts a start while idle, then counts NSTEPS multiply
// steps, one per cycle, and pulses done after the last. A start while running
// is ignored.
module gs_ctrl #(
    parameter int NSTEPS = 7,
    parameter int STW    = $clog2(NSTEPS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic [STW-1:0] step,
    output logic           last,
    output logic           done
);
    import gs_pkg::*;

    localparam logic [STW-1:0] LAST_STEP = STW'(NSTEPS - 1);

    gs_state_e state;

    // State, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GS_IDLE;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                GS_IDLE: if (start) begin
                    state <= GS_RUN;
                    step  <= '0;
                end
                GS_RUN: if (step == LAST_STEP) begin
                    state <= GS_IDLE;
                    done  <= 1'b1;
                end else begin
                    step <= step + STW'(1);
                end
                default: state <= GS_IDLE;
            endcase
        end
    end

    // Decoded status for the datapath.
    assign busy = (state == GS_RUN);
    assign last = busy && (step == LAST_STEP);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && step == $past(step) + STW'(1))); // R3
    AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (done && !busy)); // R3
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> (busy && step != '0)); // R6

endmodule

// File: rtl/gs_divider.sv
// Goldschmidt significand divider (top). It latches A and B on start, looks up
// a seed T close to 1/B, and forms n0 = A*T and d0 = B*T. It then repeats
// n = n*r and d = d*r with r = ~d (one's complement, about 2 - d). The steps
// alternate on one shared multiplier. The last numerator product plus INC
// becomes q. Assumes both operands are in [1, 2).
module gs_divider #(
    parameter int M     = 24,
    parameter int IDXW  = 6,
    parameter int SW    = 8,
    parameter int ITERS = 3,
    parameter int INC   = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    output logic         done,
    output logic [M-1:0] q
);
    localparam int NSTEPS = 2 * ITERS + 1;
    localparam int STW    = $clog2(NSTEPS);

    logic [M-1:0]   a_r, b_r, n_r, d_r, q_r;
    logic [M-1:0]   t_seed, mx, my, prod;
    logic [M:0]     fin_sum;
    logic           busy, last;
    logic [STW-1:0] step;

    gs_ctrl #(.NSTEPS(NSTEPS), .STW(STW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .step  (step),
        .last  (last),
        .done  (done)
    );

    gs_seed_rom #(.M(M), .IDXW(IDXW), .SW(SW)) u_seed (
        .idx (b_r[M-2 -: IDXW]),
        .t   (t_seed)
    );

    gs_mul_trunc #(.M(M)) u_mul (
        .x (mx),
        .y (my),
        .p (prod)
    );

    // Select the multiplier operands for the current step.
    always_comb begin
        if (step == STW'(0)) begin
            mx = a_r;
            my = t_seed;
        end else if (step == STW'(1)) begin
            mx = b_r;
            my = t_seed;
        end else if (!step[0]) begin
            mx = n_r;
            my = ~d_r;
        end else begin
            mx = d_r;
            my = ~d_r;
        end
    end

    // Final increment with saturation.
    assign fin_sum = {1'b0, prod} + (M+1)'(INC);

    // Operand capture and iteration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r <= '0;
            b_r <= '0;
            n_r <= '0;
            d_r <= '0;
            q_r <= '0;
        end else begin
            if (start && !busy) begin
                a_r <= a_in;
                b_r <= b_in;
            end
            if (busy) begin
                if (last)
                    q_r <= fin_sum[M] ? {M{1'b1}} : fin_sum[M-1:0];
                else if (!step[0])
                    n_r <= prod;
                else
                    d_r <= prod;
            end
        end
    end

    assign q = q_r;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!done && q == '0)); // R1
    AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(q)); // R5
    AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(a_r) && $stable(b_r))); // R6
    AST_D_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step >= STW'(2)) |-> (d_r[M-1] || d_r[M-2])); // R2

endmodule

// File: tb/test_gs_divider.sv
module test_gs_divider;
    localparam int M     = 24;
    localparam int ITERS = 3;
    localparam int LAT   = 2 * ITERS + 1;
    localparam longint TOL = 12;

    typedef struct {
        longint exp_q;
        longint acc_cyc;
        string  tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] a_in = '0;
    logic [M-1:0] b_in = '0;
    logic         done;
    logic [M-1:0] q;

    int     tests = 0;
    int     fails = 0;
    longint cyc = 0;
    item_t  sb[$];
    logic   prev_done = 1'b0;
    logic   have_q = 1'b0;
    logic [M-1:0] held_q = '0;
    logic [31:0]  lcg = 32'h1234_5678;

    gs_divider #(.M(M), .ITERS(ITERS)) i_gs_divider (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_in(a_in), .b_in(b_in), .done(done), .q(q)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expected items and compares them at each done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                tests++;
                if (prev_done) begin
                    fails++;
                    $display("FAIL R4: done high two cycles, actual=1 expected=0");
                end
                if (sb.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R6: unexpected done, actual=1 expected=0");
                end else begin
                    item_t it;
                    longint diff;
                    it = sb.pop_front();
                    diff = (longint'(q) > it.exp_q) ? longint'(q) - it.exp_q : it.exp_q - longint'(q);
                    tests++;
                    if (diff > TOL) begin
                        fails++;
                        $display("FAIL %s: q actual=%h expected=%h (+-%0d)", it.tag, q, it.exp_q, TOL);
                    end
                    tests++;
                    if (cyc != it.acc_cyc + LAT) begin
                        fails++;
                        $display("FAIL R3: latency actual=%0d expected=%0d", cyc - it.acc_cyc, LAT);
                    end
                end
                held_q = q;
                have_q = 1'b1;
            end else if (have_q && q !== held_q) begin
                tests++; fails++;
                $display("FAIL R5: q changed without done, actual=%h expected=%h", q, held_q);
                held_q = q;
            end
            prev_done = done;
        end
    end

    // Driver: push expectation, pulse start, wait out the run.
    task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b, input string tag);
        item_t it;
        @(negedge clk);
        it.exp_q   = (longint'(a) <<< (M - 1)) / longint'(b);
        it.acc_cyc = cyc + 1;
        it.tag     = tag;
        sb.push_back(it);
        a_in = a; b_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT + 1) @(negedge clk);
    endtask

    function automatic logic [M-1:0] rnd_sig();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return {1'b1, lcg[30:8]};
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        tests++;
        if (done !== 1'b0 || q !== '0) begin
            fails++;
            $display("FAIL R1: in reset done=%b q=%h expected done=0 q=0", done, q);
        end
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (done !== 1'b0 || q !== '0) begin
            fails++;
            $display("FAIL R1: after reset done=%b q=%h expected done=0 q=0", done, q);
        end

        // R7: identities
        run_op(24'h800000, 24'h800000, "R7");
        run_op(24'hC00000, 24'hC00000, "R7");
        run_op(24'hFFFFFF, 24'hFFFFFF, "R7");
        run_op(24'hA5A5A5, 24'h800000, "R7");
        // R8: near-2 quotients must not wrap
        run_op(24'hFFFFFF, 24'h800000, "R8");
        run_op(24'hFFFFF0, 24'h800001, "R8");
        // R2: boundary operands at table slot edges
        run_op(24'h800000, 24'hFFFFFF, "R2");
        run_op(24'hFFFFFF, 24'h81FFFF, "R2");
        run_op(24'h900000, 24'hFE0000, "R2");
        run_op(24'hB504F3, 24'hB504F3, "R2");

        // R6: start while running is ignored
        begin
            item_t it;
            @(negedge clk);
            it.exp_q   = (longint'(24'hC00000) <<< (M - 1)) / longint'(24'h800000);
            it.acc_cyc = cyc + 1;
            it.tag     = "R6";
            sb.push_back(it);
            a_in = 24'hC00000; b_in = 24'h800000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
            a_in = 24'h800000; b_in = 24'hFFFFFF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (LAT + 6) @(negedge clk);
            tests++;
            if (sb.size() != 0) begin
                fails++;
                $display("FAIL R6: pending results actual=%0d expected=0", sb.size());
            end
        end

        // R5: q holds while inputs change without start
        begin
            logic [M-1:0] snap;
            snap = q;
            a_in = 24'h812345; b_in = 24'hF00000;
            repeat (6) @(negedge clk);
            tests++;
            if (q !== snap || done !== 1'b0) begin
                fails++;
                $display("FAIL R5: q actual=%h expected=%h done=%b", q, snap, done);
            end
        end

        // R2: pseudo-random sweep
        for (int k = 0; k < 300; k++) begin
            logic [M-1:0] ra, rb;
            ra = rnd_sig();
            rb = rnd_sig();
            run_op(ra, rb, "R2");
        end

        repeat (4) @(negedge clk);
        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R3: results missing actual=%0d expected=0", sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R3: watchdog expired, actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule